// File: doc/BRIEF.md
# Frame-Timed Serial Word Transmitter with Data-Pin Release Control

This block takes a parallel word through a valid/ready handshake and sends it out MSB first, one bit per clock period, inside a frame. It also drives the output enable of the data pin. The enable rises when the first bit is launched. It drops at one of two points, chosen by configuration: on the edge after the start of the last bit (the normal release), or on the second edge after that start (the late release). The late release is honoured only when the frame strobe comes from outside the block. When the block makes the frame itself, a request for late release is ignored. At the same time the block samples a receive line and returns the word it collected, with a one-cycle valid strobe.

Everything runs on the system clock. Serial clock edges reach the block as "edge ticks". When the block is clock master, a divider of `CLK_DIV` system cycles produces one tick per half period and also drives the clock pin. When the block is clock slave, every change of the incoming clock is one tick. Frame time is counted in these ticks. For a word of `WIDTH` bits, tick 2k launches bit k and tick 2k+1 samples it. Tick 2·`WIDTH` ends the frame. When the block is clock master, that last tick is counted internally even in the modes where it never shows on the clock pin. When the block is clock slave and the clock phase is 1, the external master must supply that extra edge.

The controller has four states:
- `ST_IDLE`: ready for a word.
- `ST_ARMED`: a word is held and the block waits for the outside frame strobe.
- `ST_LEAD`: clock slave with phase 1, waiting for the launch edge of the MSB.
- `ST_SHIFT`: counting ticks.

Its transitions are:
- IDLE→SHIFT: word accepted, frame master, no lead edge needed.
- IDLE→LEAD: word accepted, frame master, lead edge needed.
- IDLE→ARMED: word accepted, frame slave.
- ARMED→SHIFT or ARMED→LEAD: the outside frame strobe becomes active.
- LEAD→SHIFT: the first external edge arrives.
- SHIFT→IDLE: tick 2·`WIDTH`.

Top module: `sertx_tristate`

## Requirements
- R1: After reset, `tx_ready` is 1 and `rx_valid` is 0. `frm_o` sits at its inactive level, which is the inverse of `cfg_frm_pol`. `sclk_o` equals `cfg_mode[1]`. `txd_oe` is 0 when `cfg_tri_en` is 1.
- R2: A word is taken on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` then stays 0 until the frame's final tick (tick 2·WIDTH).
- R3: Bits leave MSB first. Bit k of the frame (bit WIDTH-1-k of the word) is on `txd` from tick 2k until tick 2k+2. Tick 0 is the clock edge that starts the frame.
- R4: Clock-master timing. One tick falls every `CLK_DIV` system cycles, and the tick count advances on the system edge that ends each period. `cfg_mode[1]` is the idle level of `sclk_o`. With `cfg_mode[0]`=0, `sclk_o` = idle XOR (tick count bit 0). With `cfg_mode[0]`=1, `sclk_o` = NOT idle XOR (tick count bit 0). Outside a frame, `sclk_o` returns to idle.
- R5: `cfg_frm_pol`=1 means the frame is active high, 0 means active low. As frame master (`cfg_frm_slave`=0), `frm_o` is active from the word's acceptance until tick 2·WIDTH. As frame slave, `frm_o` stays inactive. After a word has been accepted, the frame starts on the first system edge at which `frm_i` is seen going from inactive to active.
- R6: With `cfg_tri_en`=0, `txd_oe` is always 1.
- R7: With `cfg_tri_en`=1 and normal release, `txd_oe` is 1 from tick 0 and falls at tick 2·WIDTH-1.
- R8: With `cfg_tri_en`=1, `cfg_late_tri`=1 and `cfg_frm_slave`=1, `txd_oe` is 1 from tick 0 and falls at tick 2·WIDTH.
- R9: With `cfg_frm_slave`=0, `cfg_late_tri` has no effect: `txd_oe` falls at tick 2·WIDTH-1.
- R10: Clock-slave mode (`cfg_clk_slave`=1). Each change of `sclk_i` is one tick, counted on the next system edge. With `cfg_mode[0]`=1, the first change is tick 0: it raises `txd_oe`. Ending the frame takes a further change after the last sampling edge.
- R11: As clock master with `cfg_mode[0]`=1, tick 2·WIDTH is generated internally. It ends the frame and performs the late release, but produces no transition on `sclk_o`.
- R12: `rxd` is sampled at every odd tick, MSB first. `rx_valid` pulses for exactly one cycle with the assembled word on `rx_data`. It is visible from the system edge of tick 2·WIDTH-1.
- R13: In clock-slave mode, `sclk_o` is held at `cfg_mode[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Block idle, word can be taken |
| tx_data | input | WIDTH | Word to send |
| cfg_mode | input | 2 | [1] idle clock level, [0] clock phase |
| cfg_frm_pol | input | 1 | 1 = frame active high |
| cfg_tri_en | input | 1 | Enable release of the data pin |
| cfg_late_tri | input | 1 | Request late release |
| cfg_frm_slave | input | 1 | 1 = frame strobe comes from `frm_i` |
| cfg_clk_slave | input | 1 | 1 = serial clock comes from `sclk_i` |
| sclk_i | input | 1 | External serial clock |
| sclk_o | output | 1 | Generated serial clock |
| frm_i | input | 1 | External frame strobe |
| frm_o | output | 1 | Generated frame strobe |
| txd | output | 1 | Serial transmit data |
| txd_oe | output | 1 | Output enable of the data pin |
| rxd | input | 1 | Serial receive data |
| rx_data | output | WIDTH | Received word |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |

## Verification
As clock master, the tick count is floor(n/`CLK_DIV`) at the n-th sample after the start edge. The bench compares `txd_oe`, `txd`, `sclk_o`, `frm_o`, `tx_ready` and `rx_valid` against that count at every sample. The `rx_valid` pulse is due exactly at n = (2·WIDTH-1)·`CLK_DIV`. As clock slave, the bench changes `sclk_i` on a falling system edge, lets one rising edge count it, and checks on the following falling edge. Phase-1 frames are offset by the lead edge. The sweep covers every combination of the four clock modes and the five control bits, using loopback receive data that alternates between true and inverted.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_LEAD  = 2'd2,
        ST_SHIFT = 2'd3
    } sertx_state_e;
endpackage

// File: rtl/sertx_tick.sv
module sertx_tick #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clk_slave,
    input  logic sclk_i,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt;
    logic          sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk_i;
            if (!run || clk_slave || cnt == CNT_TOP)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (clk_slave ? (sclk_i ^ sclk_q) : (cnt == CNT_TOP));

    // R4
    div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || clk_slave) |=> cnt == '0);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] tx_word,
    input  logic             shift_tx,
    input  logic             samp_rx,
    input  logic             rx_done,
    input  logic             rxd,
    output logic             txd,
    output logic [WIDTH-1:0] rx_data,
    output logic             rx_valid
);
    logic [WIDTH-1:0] tx_sh;
    logic [WIDTH-1:0] rx_sh;
    logic [WIDTH-1:0] rx_next;

    assign rx_next = {rx_sh[WIDTH-2:0], rxd};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            if (load)
                tx_sh <= tx_word;
            else if (shift_tx)
                tx_sh <= {tx_sh[WIDTH-2:0], 1'b0};
            if (samp_rx)
                rx_sh <= rx_next;
            rx_valid <= rx_done;
            if (rx_done)
                rx_data <= rx_next;
        end
    end

    assign txd = tx_sh[WIDTH-1];

    // R12
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
    import sertx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_valid,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_frm_pol,
    input  logic       cfg_tri_en,
    input  logic       cfg_late_tri,
    input  logic       cfg_frm_slave,
    input  logic       cfg_clk_slave,
    input  logic       frm_i,
    input  logic       tick,
    output logic       tx_ready,
    output logic       run,
    output logic       load,
    output logic       shift_tx,
    output logic       samp_rx,
    output logic       rx_done,
    output logic       txd_oe,
    output logic       sclk_o,
    output logic       frm_o
);
    localparam int EDGES = 2 * WIDTH;
    localparam int HW    = $clog2(EDGES + 1);
    localparam logic [HW-1:0] H_END  = HW'(EDGES);
    localparam logic [HW-1:0] H_LAST = HW'(EDGES - 1);

    sertx_state_e    state, state_nx;
    logic [HW-1:0]   h, h_nx;
    logic            oe_q, frm_prev;
    logic            fire, frm_act, frm_rise, late_eff, need_lead;
    logic            shift_tick, at_end, enter_shift;

    assign fire       = tx_valid && (state == ST_IDLE);
    assign frm_act    = (frm_i == cfg_frm_pol);
    assign frm_rise   = frm_act && !frm_prev;
    assign late_eff   = cfg_late_tri && cfg_frm_slave;
    assign need_lead  = cfg_clk_slave && cfg_mode[0];
    assign h_nx       = h + 1'b1;
    assign shift_tick = (state == ST_SHIFT) && tick;
    assign at_end     = (h_nx == H_END);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (fire)
                          state_nx = cfg_frm_slave ? ST_ARMED
                                   : (need_lead ? ST_LEAD : ST_SHIFT);
            ST_ARMED: if (frm_rise)
                          state_nx = need_lead ? ST_LEAD : ST_SHIFT;
            ST_LEAD:  if (tick)
                          state_nx = ST_SHIFT;
            ST_SHIFT: if (shift_tick && at_end)
                          state_nx = ST_IDLE;
        endcase
    end

    assign enter_shift = (state != ST_SHIFT) && (state_nx == ST_SHIFT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h        <= '0;
            oe_q     <= 1'b0;
            frm_prev <= 1'b0;
        end else begin
            frm_prev <= frm_act;
            if (enter_shift) begin
                h    <= '0;
                oe_q <= 1'b1;
            end else if (shift_tick) begin
                h <= h_nx;
                if (at_end || (h_nx == H_LAST && !late_eff))
                    oe_q <= 1'b0;
            end
        end
    end

    assign tx_ready = (state == ST_IDLE);
    assign run      = (state == ST_LEAD) || (state == ST_SHIFT);
    assign load     = fire;
    assign shift_tx = shift_tick && !h_nx[0] && !at_end;
    assign samp_rx  = shift_tick && h_nx[0];
    assign rx_done  = samp_rx && (h_nx == H_LAST);
    assign txd_oe   = cfg_tri_en ? oe_q : 1'b1;
    assign sclk_o   = (!cfg_clk_slave && state == ST_SHIFT)
                    ? (cfg_mode[1] ^ cfg_mode[0] ^ h[0]) : cfg_mode[1];
    assign frm_o    = (!cfg_frm_slave && run) ? cfg_frm_pol : !cfg_frm_pol;

    // R1
    idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !oe_q);
    // R2
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !tx_ready);
    // R3
    h_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (h < H_END));
    // R9
    late_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_frm_slave && state == ST_SHIFT && h == H_LAST) |-> !oe_q);
    // R10
    lead_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD) |-> !oe_q);
    // R13
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clk_slave |-> (sclk_o == cfg_mode[1]));
endmodule

// File: rtl/sertx_tristate.sv
module sertx_tristate #(
    parameter int WIDTH   = 8,
    parameter int CLK_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic [WIDTH-1:0] tx_data,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_frm_pol,
    input  logic             cfg_tri_en,
    input  logic             cfg_late_tri,
    input  logic             cfg_frm_slave,
    input  logic             cfg_clk_slave,
    input  logic             sclk_i,
    output logic             sclk_o,
    input  logic             frm_i,
    output logic             frm_o,
    output logic             txd,
    output logic             txd_oe,
    input  logic             rxd,
    output logic [WIDTH-1:0] rx_data,
    output logic             rx_valid
);
    logic tick, run, load, shift_tx, samp_rx, rx_done;

    sertx_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .clk_slave(cfg_clk_slave),
        .sclk_i(sclk_i), .tick(tick)
    );

    sertx_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .cfg_mode(cfg_mode),
        .cfg_frm_pol(cfg_frm_pol), .cfg_tri_en(cfg_tri_en),
        .cfg_late_tri(cfg_late_tri), .cfg_frm_slave(cfg_frm_slave),
        .cfg_clk_slave(cfg_clk_slave), .frm_i(frm_i), .tick(tick),
        .tx_ready(tx_ready), .run(run), .load(load), .shift_tx(shift_tx),
        .samp_rx(samp_rx), .rx_done(rx_done), .txd_oe(txd_oe),
        .sclk_o(sclk_o), .frm_o(frm_o)
    );

    sertx_shift #(.WIDTH(WIDTH)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .tx_word(tx_data),
        .shift_tx(shift_tx), .samp_rx(samp_rx), .rx_done(rx_done),
        .rxd(rxd), .txd(txd), .rx_data(rx_data), .rx_valid(rx_valid)
    );
endmodule

// File: tb/tb_sertx_tristate.sv
`timescale 1ns/1ps
module tb_sertx_tristate;
    localparam int W   = 8;
    localparam int DIV = 3;
    localparam int E2  = 2 * W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_valid = 1'b0;
    logic tx_ready;
    logic [W-1:0] tx_data = '0;
    logic [1:0] cfg_mode = 2'd0;
    logic cfg_frm_pol = 1'b1, cfg_tri_en = 1'b1, cfg_late_tri = 1'b0;
    logic cfg_frm_slave = 1'b0, cfg_clk_slave = 1'b0;
    logic sclk_i = 1'b0, frm_i = 1'b0;
    logic sclk_o, frm_o, txd, txd_oe, rx_valid;
    logic rx_inv = 1'b0;
    logic rxd;
    logic [W-1:0] rx_data;

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    assign rxd = txd ^ rx_inv;

    always #5 clk = ~clk;

    sertx_tristate #(.WIDTH(W), .CLK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .cfg_mode(cfg_mode), .cfg_frm_pol(cfg_frm_pol),
        .cfg_tri_en(cfg_tri_en), .cfg_late_tri(cfg_late_tri),
        .cfg_frm_slave(cfg_frm_slave), .cfg_clk_slave(cfg_clk_slave),
        .sclk_i(sclk_i), .sclk_o(sclk_o), .frm_i(frm_i), .frm_o(frm_o),
        .txd(txd), .txd_oe(txd_oe), .rxd(rxd), .rx_data(rx_data),
        .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // hh < 0: not yet launched; hh >= E2: frame over
    function automatic bit exp_oe(input int hh);
        if (!cfg_tri_en) return 1'b1;
        if (hh < 0 || hh >= E2) return 1'b0;
        if (hh < E2 - 1) return 1'b1;
        return cfg_late_tri && cfg_frm_slave;
    endfunction

    task automatic check_at(input int hh, input logic [W-1:0] word, input bit rxv_exp);
        string oe_req;
        if (!cfg_tri_en) oe_req = "R6 oe held";
        else if (cfg_late_tri && cfg_frm_slave) oe_req = "R8 late release";
        else if (cfg_late_tri) oe_req = "R9 late ignored as frame master";
        else oe_req = "R7 normal release";
        if (cfg_clk_slave && cfg_mode[0] && hh < 0) oe_req = {oe_req, " R10 lead"};
        chk(txd_oe == exp_oe(hh), oe_req, txd_oe, exp_oe(hh));
        if (hh >= 0 && hh < E2)
            chk(txd == word[W-1-hh/2], "R3 msb first", txd, word[W-1-hh/2]);
        if (cfg_clk_slave)
            chk(sclk_o == cfg_mode[1], "R13 sclk idle as slave", sclk_o, cfg_mode[1]);
        else begin
            logic e;
            e = (hh >= 0 && hh < E2) ? (cfg_mode[1] ^ cfg_mode[0] ^ hh[0]) : cfg_mode[1];
            chk(sclk_o == e, hh == E2 ? "R11 hidden end edge" : "R4 clock mode", sclk_o, e);
        end
        begin
            logic ef;
            ef = (!cfg_frm_slave && hh < E2) ? cfg_frm_pol : !cfg_frm_pol;
            chk(frm_o == ef, "R5 frame out", frm_o, ef);
        end
        chk(tx_ready == (hh >= E2), "R2 ready", tx_ready, hh >= E2);
        chk(rx_valid == rxv_exp, "R12 rx strobe", rx_valid, rxv_exp);
        if (rxv_exp)
            chk(rx_data == (word ^ {W{rx_inv}}), "R12 rx data", rx_data, word ^ {W{rx_inv}});
    endtask

    task automatic run_frame(input logic [W-1:0] word);
        @(negedge clk);
        tx_data  = word;
        tx_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        if (cfg_frm_slave) begin
            chk(tx_ready == 1'b0, "R2 armed not ready", tx_ready, 0);
            chk(txd_oe == exp_oe(-1), "R5 armed oe", txd_oe, exp_oe(-1));
            chk(frm_o == !cfg_frm_pol, "R5 slave frame out", frm_o, !cfg_frm_pol);
            frm_i = cfg_frm_pol;
            @(posedge clk);
            @(negedge clk);
        end
        if (!cfg_clk_slave) begin
            for (int n = 0; n <= E2 * DIV + 2; n++) begin
                check_at(n / DIV, word, n == (E2 - 1) * DIV);
                @(negedge clk);
            end
        end else begin
            int last_t;
            last_t = cfg_mode[0] ? E2 + 1 : E2;
            for (int t = 0; t <= last_t; t++) begin
                int hh;
                hh = cfg_mode[0] ? t - 1 : t;
                check_at(hh, word, hh == E2 - 1);
                if (t < last_t) begin
                    sclk_i = ~sclk_i;
                    @(posedge clk);
                    @(negedge clk);
                end
            end
        end
        frm_i = !cfg_frm_pol;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int idx;
        idx = 0;
        frm_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_ready == 1'b1, "R1 ready", tx_ready, 1);
        chk(txd_oe == 1'b0, "R1 oe", txd_oe, 0);
        chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        chk(frm_o == 1'b0, "R1 frame", frm_o, 0);
        chk(sclk_o == 1'b0, "R1 sclk", sclk_o, 0);
        for (int cfg = 0; cfg < 128; cfg++) begin
            logic [6:0] c;
            c = 7'(cfg);
            cfg_mode      = c[1:0];
            cfg_frm_pol   = c[2];
            cfg_tri_en    = c[3];
            cfg_late_tri  = c[4];
            cfg_frm_slave = c[5];
            cfg_clk_slave = c[6];
            frm_i         = !c[2];
            sclk_i        = c[1];
            rx_inv        = c[0] ^ c[3];
            repeat (2) @(negedge clk);
            run_frame(W'(idx * 37 + 8'h5A));
            idx++;
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule